// File: doc/BRIEF.md
# Peripheral Clock Mailbox Controller

This block gives each of a set of peripherals its own clock-enable stream, derived from the master clock. Every peripheral can be switched on or off on its own and runs at the master rate divided by 1, 2, 4 or 8. Software does not get one register per peripheral. It reaches all of them through a single command port, which carries a read/write bit, a peripheral index, an enable flag and a 2-bit divider code.

A write command stores the enable flag and the divider code for the indexed peripheral. A read command returns the stored settings of the indexed peripheral on the readback outputs one cycle later and raises a valid strobe. Each channel is a two-state machine. In CH_OFF the output stays low and the counter is held. In CH_RUN the channel counts through its divided period and produces a one-cycle pulse at count zero. The transitions are CH_OFF→CH_RUN, taken when the stored enable is set, and CH_RUN→CH_OFF, taken when the stored enable is cleared. Inside CH_RUN, a new divider code is picked up only at the period boundary.

Top module: `pclk_mailbox`

## Requirements
- R1: After reset every channel is disabled with divider code 00, `pclk_en` is all zero, and `rd_valid`, `rd_enable` and `rd_div` are zero.
- R2: A command with `cmd_valid`=1 and `cmd_write`=1 and an in-range index stores `cmd_enable` and `cmd_div` for that channel only. It does not raise `rd_valid`.
- R3: A command with `cmd_valid`=1 and `cmd_write`=0 drives `rd_valid`=1 in the following cycle, together with the indexed channel's stored enable on `rd_enable` and its divider code on `rd_div`. In any other cycle `rd_valid` is 0.
- R4: Divider code 00 gives a pulse every cycle, 01 every 2 cycles, 10 every 4 cycles and 11 every 8 cycles. Each pulse is one cycle high.
- R5: When a write enables a stopped channel at clock edge E, that channel's `pclk_en` bit is low after E and high after edge E+1.
- R6: A divider change written while a channel runs takes effect only at the end of the current period. The interval in progress keeps its old length, and the next intervals use the new one.
- R7: When a write disables a channel, its `pclk_en` bit is low from the next cycle on and stays low. Its counter does not advance, so a later enable restarts with the R5 latency.
- R8: A write whose index is at or above `NUM_PERIPH` changes no channel. A read of such an index returns `rd_enable`=0 and `rd_div`=00.
- R9: Channels are independent: enabling, disabling or re-dividing one channel leaves the pulse spacing of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_write | input | 1 | 1 = store settings, 0 = read settings back |
| cmd_index | input | IDX_W | Peripheral index |
| cmd_enable | input | 1 | Enable flag for a write |
| cmd_div | input | 2 | Divider code for a write (00=/1, 01=/2, 10=/4, 11=/8) |
| rd_valid | output | 1 | Readback fields were updated by a read command |
| rd_enable | output | 1 | Readback of the stored enable |
| rd_div | output | 2 | Readback of the stored divider code |
| pclk_en | output | NUM_PERIPH | Per-peripheral divided clock-enable pulses |

## Verification
The bench builds the block with `NUM_PERIPH`=6 and the default `IDX_W`=5. With those values, indices 6 to 31 can be encoded but are not implemented, so the ignore-on-write and zero-on-read rules for out-of-range indices can be checked through the normal port. Six channels are also enough to run two channels at different rates side by side and to change one of them while watching the other.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    localparam int DIV_W = 2;
    localparam int CNT_W = (1 << DIV_W) - 1;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } ch_state_t;

    function automatic logic [CNT_W-1:0] last_count(input logic [DIV_W-1:0] code);
        return CNT_W'((1 << code) - 1);
    endfunction

endpackage

// File: rtl/pclk_channel.sv
module pclk_channel
    import pclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_div,
    output logic             cfg_en_o,
    output logic [DIV_W-1:0] cfg_div_o,
    output logic             tick_o
);

    ch_state_t        st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [DIV_W-1:0] act_div, act_div_n;
    logic             cfg_en;
    logic [DIV_W-1:0] cfg_div;
    logic             at_end;

    // Stored settings, written through the mailbox
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en  <= 1'b0;
            cfg_div <= '0;
        end else if (wr_stb) begin
            cfg_en  <= wr_en;
            cfg_div <= wr_div;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= CH_OFF;
            cnt     <= '0;
            act_div <= '0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            act_div <= act_div_n;
        end
    end

    assign at_end = (cnt == last_count(act_div));

    // Next-state logic
    always_comb begin
        st_n      = st;
        cnt_n     = cnt;
        act_div_n = act_div;
        unique case (st)
            CH_OFF: begin
                cnt_n = '0;
                if (cfg_en) begin
                    st_n      = CH_RUN;
                    act_div_n = cfg_div;
                end
            end
            CH_RUN: begin
                if (!cfg_en) begin
                    st_n  = CH_OFF;
                    cnt_n = '0;
                end else if (at_end) begin
                    cnt_n     = '0;
                    act_div_n = cfg_div;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: st_n = CH_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        cfg_en_o  = cfg_en;
        cfg_div_o = cfg_div;
        tick_o    = (st == CH_RUN) && (cnt == '0) && cfg_en;
    end

    assert_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_OFF && !cfg_en && !wr_stb) |=> (cnt == '0 && !tick_o));

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_RUN) |-> (cnt <= last_count(act_div)));

    assert_div_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_RUN && !at_end) |=> $stable(act_div));

endmodule

// File: rtl/pclk_mailbox.sv
module pclk_mailbox
    import pclk_pkg::*;
#(
    parameter int NUM_PERIPH = 32,
    parameter int IDX_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic                  cmd_write,
    input  logic [IDX_W-1:0]      cmd_index,
    input  logic                  cmd_enable,
    input  logic [1:0]            cmd_div,
    output logic                  rd_valid,
    output logic                  rd_enable,
    output logic [1:0]            rd_div,
    output logic [NUM_PERIPH-1:0] pclk_en
);

    logic [NUM_PERIPH-1:0] cfg_en;
    logic [DIV_W-1:0]      cfg_div [NUM_PERIPH];
    logic [NUM_PERIPH-1:0] wr_stb;
    logic                  sel_en;
    logic [DIV_W-1:0]      sel_div;
    logic                  in_range;

    assign in_range = (32'(cmd_index) < NUM_PERIPH);

    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_ch
        assign wr_stb[g] = cmd_valid && cmd_write && (32'(cmd_index) == g);
        pclk_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (wr_stb[g]),
            .wr_en    (cmd_enable),
            .wr_div   (cmd_div),
            .cfg_en_o (cfg_en[g]),
            .cfg_div_o(cfg_div[g]),
            .tick_o   (pclk_en[g])
        );
    end

    // Readback select
    always_comb begin
        sel_en  = 1'b0;
        sel_div = '0;
        for (int i = 0; i < NUM_PERIPH; i++) begin
            if (32'(cmd_index) == i) begin
                sel_en  = cfg_en[i];
                sel_div = cfg_div[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_enable <= 1'b0;
            rd_div    <= '0;
        end else if (cmd_valid && !cmd_write) begin
            rd_valid  <= 1'b1;
            rd_enable <= in_range ? sel_en  : 1'b0;
            rd_div    <= in_range ? sel_div : '0;
        end else begin
            rd_valid  <= 1'b0;
        end
    end

    assert_rd_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write) |=> rd_valid);

    assert_wr_no_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_write) |=> !rd_valid);

    assert_oor_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write && !in_range) |=> (!rd_enable && rd_div == 2'b00));

    assert_wr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));

endmodule

// File: tb/tb_pclk_mailbox.sv
module tb_pclk_mailbox;

    localparam int NP = 6;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [IW-1:0] cmd_index = '0;
    logic          cmd_enable = 1'b0;
    logic [1:0]    cmd_div = 2'b00;
    logic          rd_valid;
    logic          rd_enable;
    logic [1:0]    rd_div;
    logic [NP-1:0] pclk_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic       m_en  [32];
    logic [1:0] m_div [32];
    logic [2:0] exp_q [$];
    string      req_q [$];

    always #5 clk = ~clk;

    pclk_mailbox #(.NUM_PERIPH(NP), .IDX_W(IW)) dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: one command, sets inputs at a negedge and clears them at the next
    task automatic do_cmd(input bit wr, input int idx, input bit en, input logic [1:0] dv);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_write  = wr;
        cmd_index  = IW'(idx);
        cmd_enable = en;
        cmd_div    = dv;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic wr_cmd(input int idx, input bit en, input logic [1:0] dv);
        if (idx < NP) begin
            m_en[idx]  = en;
            m_div[idx] = dv;
        end
        do_cmd(1'b1, idx, en, dv);
    endtask

    task automatic rd_cmd(input int idx, input string req);
        exp_q.push_back({m_en[idx], m_div[idx]});
        req_q.push_back(req);
        do_cmd(1'b0, idx, 1'b0, 2'b00);
    endtask

    // Monitor: pops expected readback when the design flags it
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected rd_valid", 1, 0);
            end else begin
                logic [2:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check({rd_enable, rd_div} == e, r, int'({rd_enable, rd_div}), int'(e));
            end
        end
    end

    // Counts negedges until the channel's pulse is seen
    task automatic wait_tick(input int ch, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pclk_en[ch] && n < 100);
    endtask

    task automatic chk_interval(input int ch, input int per, input string req);
        int n;
        wait_tick(ch, n);
        for (int k = 0; k < 3; k++) begin
            wait_tick(ch, n);
            check(n == per, req, n, per);
        end
    endtask

    initial begin
        int n;
        for (int i = 0; i < 32; i++) begin
            m_en[i]  = 1'b0;
            m_div[i] = 2'b00;
        end
        repeat (3) @(negedge clk);
        check(pclk_en == '0, "R1 pclk_en at reset", int'(pclk_en), 0);
        check({rd_valid, rd_enable, rd_div} == 4'b0, "R1 readback at reset",
              int'({rd_valid, rd_enable, rd_div}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NP; i++) rd_cmd(i, "R1 reset settings");

        // R5 latency and R4 divide-by-1
        wr_cmd(0, 1'b1, 2'b00);
        check(pclk_en[0] == 1'b0, "R5 low after enabling edge", int'(pclk_en[0]), 0);
        @(negedge clk);
        check(pclk_en[0] == 1'b1, "R5 high after next edge", int'(pclk_en[0]), 1);
        chk_interval(0, 1, "R4 code 00 period");
        rd_cmd(0, "R2 stored settings ch0");
        rd_cmd(1, "R2 ch1 untouched");

        // R4 other codes on ch1
        wr_cmd(1, 1'b1, 2'b01);
        chk_interval(1, 2, "R4 code 01 period");
        wr_cmd(1, 1'b1, 2'b10);
        chk_interval(1, 4, "R4 code 10 period");
        wr_cmd(1, 1'b1, 2'b11);
        chk_interval(1, 8, "R4 code 11 period");
        rd_cmd(1, "R3 readback ch1");

        // R9 independence: ch2 at /4 while ch1 at /8, then ch1 disabled
        wr_cmd(2, 1'b1, 2'b10);
        chk_interval(1, 8, "R9 ch1 unaffected by ch2");
        chk_interval(2, 4, "R9 ch2 alongside ch1");
        wr_cmd(0, 1'b0, 2'b00);
        chk_interval(2, 4, "R9 ch2 after ch0 disable");

        // R7 disable holds low, re-enable restarts
        begin
            int hi = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (pclk_en[0]) hi++;
            end
            check(hi == 0, "R7 disabled output stays low", hi, 0);
        end
        wr_cmd(0, 1'b1, 2'b11);
        check(pclk_en[0] == 1'b0, "R7 restart latency low", int'(pclk_en[0]), 0);
        @(negedge clk);
        check(pclk_en[0] == 1'b1, "R7 restart latency high", int'(pclk_en[0]), 1);

        // R6 divider change at period boundary on ch0 (/8 -> /1)
        wait_tick(0, n);
        wait_tick(0, n);
        wr_cmd(0, 1'b1, 2'b00);
        wait_tick(0, n);
        check(n + 2 == 8, "R6 old interval completes", n + 2, 8);
        wait_tick(0, n);
        check(n == 1, "R6 new interval", n, 1);

        // R8 out-of-range index
        wr_cmd(3, 1'b0, 2'b00);
        wr_cmd(1, 1'b0, 2'b00);
        wr_cmd(2, 1'b0, 2'b00);
        wr_cmd(0, 1'b0, 2'b00);
        do_cmd(1'b1, 7, 1'b1, 2'b11);
        repeat (10) @(negedge clk);
        check(pclk_en == '0, "R8 write to index 7 ignored", int'(pclk_en), 0);
        rd_cmd(7, "R8 read index 7 zero");
        do_cmd(1'b1, 31, 1'b1, 2'b10);
        rd_cmd(31, "R8 read index 31 zero");
        for (int i = 0; i < NP; i++) rd_cmd(i, "R8 in-range channels unchanged");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule